// File: doc/BRIEF.md
# Canonical Signed Digit Shift-Add Multiplier

This block multiplies an unsigned data word by an unsigned coefficient. It never uses an array multiplier. When `start` is accepted, the coefficient is rewritten into canonical signed digit form. Each digit is one of minus one, zero or plus one, and no two neighbouring digits are both nonzero. The block then works through the nonzero digits from the least significant upward, one per clock. Each step adds or subtracts the data word shifted left by that digit's position. The shift is pure wiring, so each step costs a single adder pass. Zero digits cost no cycles.

A coefficient with long runs of ones, such as 0xFF, collapses to two nonzero digits: +2^8 and −2^0. No coefficient ever needs more than about half of the digit positions. The recoded digit vector is held on an output port, so software-free inspection and test equipment can see exactly which terms were applied. The product stays on its output from the `done` pulse until the next operation completes.

Top module: `csd_shift_mult`

## Requirements
- R1: After reset, `busy`, `done`, `product` and `csd_digits` are all zero.
- R2: `csd_digits` holds COEF_W+1 digits. Bits [2i+1:2i] carry the digit of weight 2^i, coded 00 = 0, 01 = +1, 11 = −1; the code 10 never appears. The signed sum of the digits equals the coefficient captured by the accepted `start`.
- R3: No two adjacent digit positions in `csd_digits` are both nonzero.
- R4: At most (COEF_W+2)/2 digits are nonzero, which is 5 for COEF_W = 8.
- R5: When `done` is high, `product` equals x_in × coef_in as captured at the accepted `start`, in DATA_W+COEF_W bits. It keeps that value, unaffected by changes on `coef_in` or `x_in`, until the next operation finishes.
- R6: `done` is a one-cycle pulse. It rises max(K,1) rising edges after the edge that accepted `start`, where K is the number of nonzero digits. `busy` is high from the accepting edge until `done` rises, and exactly one digit is consumed per busy cycle.
- R7: A `start` seen while `busy` is high is ignored. The running operation's digits, data and result are unchanged.
- R8: A zero coefficient gives a zero product, with `done` one edge after acceptance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin an operation when idle |
| coef_in | input | COEF_W | Unsigned coefficient |
| x_in | input | DATA_W | Unsigned data word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| product | output | DATA_W+COEF_W | Held result |
| csd_digits | output | 2*(COEF_W+1) | Recoded digits of the current coefficient |

## Verification
The assertions assume that `coef_in` and `x_in` are only meaningful on the accepting edge, and that an extra `start` during an operation may occur but must not disturb it. The bench follows that contract. It holds the operands steady around each accepted `start`, and it deliberately pulses `start` with different operands mid-operation only in the scenario that checks R7. Every 8-bit coefficient is exercised with two data words. The bench computes the digit vector, its weight and the latency with its own modular recoding rule, not the bit-pair rule used in the RTL.

// File: rtl/csd_pkg.sv
package csd_pkg;

  typedef enum logic [1:0] {
    DIG_ZERO = 2'b00,
    DIG_POS  = 2'b01,
    DIG_NEG  = 2'b11
  } csd_digit_e;

  // One recoding position: current bit, next higher bit, incoming carry.
  // Returns {carry_out, digit code}.
  function automatic logic [2:0] csd_step(input logic b, input logic bn, input logic ci);
    logic [1:0] s;
    s = {1'b0, b} + {1'b0, ci};
    case (s)
      2'd1:    return bn ? {1'b1, DIG_NEG} : {1'b0, DIG_POS};
      2'd2:    return {1'b1, DIG_ZERO};
      default: return {1'b0, DIG_ZERO};
    endcase
  endfunction

endpackage

// File: rtl/csd_recoder.sv
module csd_recoder #(
  parameter int COEF_W = 8
) (
  input  logic [COEF_W-1:0]       coef,
  output logic [2*(COEF_W+1)-1:0] digits,
  output logic                    carry_out
);
  import csd_pkg::*;

  logic [COEF_W+1:0] ext;
  logic [COEF_W+1:0] carry;

  assign ext      = {2'b00, coef};
  assign carry[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i <= COEF_W; i++) begin : g_pos
      logic [2:0] st;
      assign st                  = csd_step(ext[i], ext[i+1], carry[i]);
      assign digits[2*i+1 -: 2]  = st[1:0];
      assign carry[i+1]          = st[2];
    end
  endgenerate

  assign carry_out = carry[COEF_W+1];
endmodule

// File: rtl/csd_pick_lowest.sv
module csd_pick_lowest #(
  parameter int POS_N = 9,
  parameter int IDX_W = 4
) (
  input  logic [POS_N-1:0] pending,
  output logic [POS_N-1:0] lowest,
  output logic [IDX_W-1:0] idx
);
  assign lowest = pending & (~pending + 1'b1);

  always_comb begin
    idx = '0;
    for (int i = POS_N - 1; i >= 0; i--) begin
      if (pending[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/csd_term.sv
module csd_term #(
  parameter int DATA_W = 8,
  parameter int ACC_W  = 18,
  parameter int IDX_W  = 4
) (
  input  logic [DATA_W-1:0]       x,
  input  logic [IDX_W-1:0]        shamt,
  input  logic                    neg,
  output logic signed [ACC_W-1:0] term
);
  logic [ACC_W-1:0] mag;

  assign mag  = {{(ACC_W-DATA_W){1'b0}}, x} << shamt;
  assign term = neg ? -$signed(mag) : $signed(mag);
endmodule

// File: rtl/csd_shift_mult.sv
module csd_shift_mult #(
  parameter int DATA_W = 8,
  parameter int COEF_W = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [COEF_W-1:0]          coef_in,
  input  logic [DATA_W-1:0]          x_in,
  output logic                       busy,
  output logic                       done,
  output logic [DATA_W+COEF_W-1:0]   product,
  output logic [2*(COEF_W+1)-1:0]    csd_digits
);
  localparam int POS_N  = COEF_W + 1;
  localparam int IDX_W  = $clog2(POS_N);
  localparam int ACC_W  = DATA_W + COEF_W + 2;
  localparam int PROD_W = DATA_W + COEF_W;
  localparam int DIG_W  = 2 * POS_N;
  localparam int VAL_W  = COEF_W + 3;

  logic [DIG_W-1:0]        recoded;
  logic                    rec_carry;
  logic [DIG_W-1:0]        dig_q;
  logic [POS_N-1:0]        pending_q, pending_next;
  logic [POS_N-1:0]        nz_rec, nz_q, neg_q;
  logic [POS_N-1:0]        lowest;
  logic [IDX_W-1:0]        idx;
  logic [DATA_W-1:0]       x_q;
  logic signed [ACC_W-1:0] acc_q, acc_next, term;
  logic [PROD_W-1:0]       prod_q;
  logic                    busy_q, done_q;
  logic                    accept, step_fire, finish, term_neg;

  csd_recoder #(.COEF_W(COEF_W)) u_recoder (
    .coef(coef_in), .digits(recoded), .carry_out(rec_carry)
  );

  genvar g;
  generate
    for (g = 0; g < POS_N; g++) begin : g_mask
      assign nz_rec[g] = recoded[2*g];
      assign nz_q[g]   = dig_q[2*g];
      assign neg_q[g]  = dig_q[2*g+1];
    end
  endgenerate

  csd_pick_lowest #(.POS_N(POS_N), .IDX_W(IDX_W)) u_pick (
    .pending(pending_q), .lowest(lowest), .idx(idx)
  );

  assign term_neg = |(lowest & neg_q);

  csd_term #(.DATA_W(DATA_W), .ACC_W(ACC_W), .IDX_W(IDX_W)) u_term (
    .x(x_q), .shamt(idx), .neg(term_neg), .term(term)
  );

  assign acc_next     = acc_q + term;
  assign pending_next = pending_q & ~lowest;
  assign accept       = start && !busy_q;
  assign step_fire    = busy_q && (pending_q != '0);
  assign finish       = busy_q && (pending_next == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      dig_q     <= '0;
      pending_q <= '0;
      x_q       <= '0;
      acc_q     <= '0;
      prod_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (accept) begin
        busy_q    <= 1'b1;
        dig_q     <= recoded;
        pending_q <= nz_rec;
        x_q       <= x_in;
        acc_q     <= '0;
      end else if (busy_q) begin
        if (step_fire) begin
          acc_q     <= acc_next;
          pending_q <= pending_next;
        end
        if (finish) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
          prod_q <= step_fire ? acc_next[PROD_W-1:0] : acc_q[PROD_W-1:0];
        end
      end
    end
  end

  assign busy       = busy_q;
  assign done       = done_q;
  assign product    = prod_q;
  assign csd_digits = dig_q;

  function automatic logic signed [VAL_W-1:0] digit_value(input logic [DIG_W-1:0] d);
    logic signed [VAL_W-1:0] v;
    v = '0;
    for (int i = 0; i < POS_N; i++) begin
      if (d[2*i]) begin
        if (d[2*i+1]) v = v - (VAL_W'(1) << i);
        else          v = v + (VAL_W'(1) << i);
      end
    end
    return v;
  endfunction

  assert_digit_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (neg_q & ~nz_q) == '0);
  assert_recode_closed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> !rec_carry);
  assert_digit_sum_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> digit_value(dig_q) == $signed({3'b000, $past(coef_in)}));
  assert_no_adjacent_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (nz_q & (nz_q >> 1)) == '0);
  assert_weight_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(nz_q) <= (COEF_W + 2) / 2);
  assert_product_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !finish |=> $stable(prod_q));
  assert_one_digit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step_fire |=> ($countones(pending_q) + 1 == $countones($past(pending_q))));
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
  assert_done_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> !busy_q);
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start) |=> ($stable(dig_q) && $stable(x_q)));
endmodule

// File: tb/tb_csd_shift_mult.sv
module tb_csd_shift_mult;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int PN = CW + 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [CW-1:0]     coef_in = '0;
  logic [DW-1:0]     x_in = '0;
  logic              busy, done;
  logic [DW+CW-1:0]  product;
  logic [2*PN-1:0]   csd_digits;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  csd_shift_mult #(.DATA_W(DW), .COEF_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .coef_in(coef_in), .x_in(x_in),
    .busy(busy), .done(done), .product(product), .csd_digits(csd_digits)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=%0d expected<=150000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Modular recoding: odd value -> digit 2 - (v mod 4), then halve.
  function automatic logic [2*PN-1:0] ref_naf(input int c);
    logic [2*PN-1:0] r;
    int v;
    r = '0;
    v = c;
    for (int i = 0; i < PN; i++) begin
      if (v % 2 == 1) begin
        if (v % 4 == 1) begin r[2*i +: 2] = 2'b01; v = v - 1; end
        else            begin r[2*i +: 2] = 2'b11; v = v + 1; end
      end
      v = v / 2;
    end
    return r;
  endfunction

  function automatic int ref_weight(input logic [2*PN-1:0] d);
    int n;
    n = 0;
    for (int i = 0; i < PN; i++) if (d[2*i +: 2] != 2'b00) n++;
    return n;
  endfunction

  task automatic run_op(input int c, input int x, output int lat, output bit busy_ok);
    @(negedge clk);
    coef_in = CW'(c);
    x_in    = DW'(x);
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    busy_ok = busy;
    lat = 0;
    while (lat < 30) begin
      @(negedge clk);
      lat++;
      if (done) break;
    end
  endtask

  task automatic test_reset();
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(product == '0, "R1 product", product, 0);
    chk(csd_digits == '0, "R1 digits", csd_digits, 0);
  endtask

  task automatic check_digits(input int c);
    logic [2*PN-1:0] d;
    int sum, adj, bad;
    d = csd_digits;
    sum = 0; adj = 0; bad = 0;
    for (int i = 0; i < PN; i++) begin
      case (d[2*i +: 2])
        2'b01: sum += (1 << i);
        2'b11: sum -= (1 << i);
        2'b10: bad++;
        default: ;
      endcase
      if (i > 0 && d[2*i] && d[2*i-2]) adj++;
    end
    chk(bad == 0, "R2 code 10 absent", bad, 0);
    chk(sum == c, "R2 digit sum", sum, c);
    chk(d == ref_naf(c), "R2 digit vector", d, ref_naf(c));
    chk(adj == 0, "R3 adjacent nonzero", adj, 0);
    chk(ref_weight(d) <= (CW + 2) / 2, "R4 weight bound", ref_weight(d), (CW + 2) / 2);
  endtask

  task automatic test_all_coefs();
    int lat, k, expl, x;
    bit bok;
    for (int c = 0; c < (1 << CW); c++) begin
      for (int j = 0; j < 2; j++) begin
        x = (j == 0) ? 255 : ((c * 37 + 11) & 255);
        run_op(c, x, lat, bok);
        k = ref_weight(ref_naf(c));
        expl = (k == 0) ? 1 : k;
        chk(lat == expl, "R6 latency", lat, expl);
        chk(bok == 1'b1, "R6 busy after accept", bok, 1);
        chk(product == longint'(x * c), "R5 product", product, x * c);
        if (j == 0) check_digits(c);
        @(negedge clk);
        chk(done == 1'b0, "R6 done pulse width", done, 0);
      end
    end
  endtask

  task automatic test_zero_coef();
    int lat;
    bit bok;
    run_op(0, 255, lat, bok);
    chk(lat == 1, "R8 zero latency", lat, 1);
    chk(product == '0, "R8 zero product", product, 0);
    chk(csd_digits == '0, "R8 zero digits", csd_digits, 0);
  endtask

  task automatic test_start_ignored();
    int lat;
    @(negedge clk);
    coef_in = 8'hAB; x_in = 8'h5C; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    coef_in = 8'hFF; x_in = 8'h01; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (lat < 30 && !done) begin
      @(negedge clk);
      lat++;
    end
    chk(lat == 5, "R7 latency unchanged", lat, 5);
    chk(product == 16'(8'h5C * 8'hAB), "R7 product unchanged", product, 8'h5C * 8'hAB);
    chk(csd_digits == ref_naf(8'hAB), "R7 digits unchanged", csd_digits, ref_naf(8'hAB));
  endtask

  task automatic test_hold();
    int lat;
    bit bok;
    run_op(8'hC7, 8'hE3, lat, bok);
    coef_in = 8'h12; x_in = 8'h34;
    repeat (5) @(negedge clk);
    chk(product == 16'(8'hC7 * 8'hE3), "R5 product hold", product, 8'hC7 * 8'hE3);
    chk(csd_digits == ref_naf(8'hC7), "R5 digits hold", csd_digits, ref_naf(8'hC7));
    chk(busy == 1'b0, "R5 idle without start", busy, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    test_reset();
    rst_n = 1'b1;
    @(negedge clk);
    test_reset();
    test_zero_coef();
    test_all_coefs();
    test_start_ignored();
    test_hold();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule